// File: doc/BRIEF.md
# Thermal Throttle and Operating-Point Governor

This block turns a stream of digital die-temperature samples into three thermal responses of rising severity. When the die reaches a passive trip level, it first moves the voltage/frequency operating point one step down a small table. If the die still reaches the junction limit, it removes a growing fraction of clock cycles and leaves the programmed frequency alone. If the die then reaches a critical level while cycles are already being skipped, it raises a hard-reset request. The reset request stays high until the block's own reset.

Operating-point changes follow the supply rule: the voltage must never be too low for the frequency in use. When stepping down, the block lowers the frequency selection first and the voltage selection one cycle later. When stepping up, it raises the voltage selection first and waits for the regulator's settle indication before it raises the frequency. A programmable minimum dwell, counted in samples, separates consecutive operating-point changes so that the governor does not dither. A hysteresis band below each threshold stops the block from stepping back as soon as the temperature crosses the threshold.

Top module: `thermal_governor`

## Requirements
- R1: After reset, all three selections (operating point, frequency, voltage) are 0, the skip level is 0, clk_en is 1, reset_req is 0 and tier is 0.
- R2: Operating-point index 0 is the fastest entry and index NUM_OPP-1 (3) the slowest. A sample at or above 80 steps the point one entry slower when the sequencer is idle, the dwell is satisfied and the point is not already the slowest. At the slowest entry, further hot samples change nothing.
- R3: A sample below 77 (80 minus a hysteresis of 3) steps the point one entry faster under the same idle and dwell conditions. Samples from 77 to 79 leave the point unchanged.
- R4: After a change completes, the first dwell_min samples taken in the idle state cannot start a change. The next qualifying sample starts one. With dwell_min of 0, the first qualifying sample starts a change.
- R5: On a step down, freq_sel takes the new index on the clock edge that registers the sample, and volt_sel takes it one cycle later. opp_idx takes the new index only on the edge that registers settle_done.
- R6: On a step up, volt_sel takes the new index on the clock edge that registers the sample, while freq_sel and opp_idx stay put. Both take the new index on the edge that registers settle_done. freq_sel is never a faster index than volt_sel.
- R7: The skip level N rises by one on each sample at or above tj_limit, up to a maximum of 7. It falls by one on each sample below tj_limit minus 3. It holds for samples in between.
- R8: In any 16 consecutive cycles with no trip, clk_en is high in exactly 2*(8-N) of them.
- R9: The junction threshold is the tj_limit input. With tj_limit at 105, a sample of 104 does not raise the skip level and a sample of 105 does.
- R10: reset_req rises after a sample at or above 110 only if the skip level was already non-zero when that sample arrived. Such a sample with skip level 0 does not trip, and a sample of 109 never trips.
- R11: Once set, reset_req stays high and clk_en stays low whatever the later samples are, until rst_n is asserted.
- R12: tier reads 3 when tripped. Otherwise it reads 2 when the skip level is non-zero, 1 when freq_sel or volt_sel is non-zero, and 0 in all other cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the only way to clear a trip |
| sample_valid | input | 1 | One-cycle strobe marking a new temperature sample |
| temp_in | input | TEMP_W (8) | Die temperature in degrees, valid with the strobe |
| tj_limit | input | TEMP_W (8) | Junction threshold for cycle skipping (100 to 105) |
| dwell_min | input | DWELL_W (8) | Minimum idle samples between operating-point changes |
| settle_done | input | 1 | Regulator reports that the requested voltage is stable |
| opp_idx | output | OPP_W (2) | Operating point in effect |
| freq_sel | output | OPP_W (2) | Table index driving the clock generator |
| volt_sel | output | OPP_W (2) | Table index driving the regulator |
| skip_level | output | PH_W (3) | Cycles skipped out of every 8 |
| clk_en | output | 1 | Clock-enable stream for the gated domain |
| reset_req | output | 1 | Sticky hard-reset request |
| tier | output | 2 | Escalation tier currently active |

## Verification
The hardest state to reach from the ports is a trip. A trip needs a critical sample, but it also needs the skip stage to be active already, so one hot sample can never trip the block. The bench reaches it in three samples: one at 112, which only raises the skip level; one at 109, which sits just below the critical level; and one at 110. This also covers both sides of the critical boundary. Dwell behaviour depends on how many idle samples have passed since the last completed change. To keep that count known, the bench resets the block before each phase and varies dwell_min between steps, including 0.

// File: rtl/thermal_pkg.sv
// Shared types for the thermal governor.
// Assumes: the tier encoding is visible at the top-level port, so its values are fixed.
package thermal_pkg;

    typedef enum logic [1:0] {
        TIER_NONE    = 2'd0,
        TIER_PASSIVE = 2'd1,
        TIER_SKIP    = 2'd2,
        TIER_TRIP    = 2'd3
    } tier_e;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_DN_VOLT = 2'd1,
        SEQ_DN_WAIT = 2'd2,
        SEQ_UP_WAIT = 2'd3
    } seq_e;

endpackage

// File: rtl/tg_opp_seq.sv
// Operating-point sequencer.
// Steps the table index one entry at a time, using the passive trip level and a
// hysteresis band. Keeps freq/volt ordering safe and enforces a sample-count dwell.
// Assumes: settle_done is a pulse from the regulator after each voltage request;
// index 0 is the fastest entry.
module tg_opp_seq #(
    parameter int TEMP_W  = 8,
    parameter int NUM_OPP = 4,
    parameter int DWELL_W = 8,
    parameter int PASSIVE = 80,
    parameter int HYST    = 3,
    localparam int OPP_W  = $clog2(NUM_OPP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_valid,
    input  logic [TEMP_W-1:0]  temp,
    input  logic [DWELL_W-1:0] dwell_min,
    input  logic               settle_done,
    output logic [OPP_W-1:0]   opp_idx,
    output logic [OPP_W-1:0]   freq_sel,
    output logic [OPP_W-1:0]   volt_sel
);
    import thermal_pkg::*;

    localparam logic [OPP_W-1:0]  OPP_LAST = OPP_W'(NUM_OPP - 1);
    localparam logic [TEMP_W:0]   HOT_LVL  = (TEMP_W+1)'(PASSIVE);
    localparam logic [TEMP_W:0]   HYST_EXT = (TEMP_W+1)'(HYST);

    seq_e               state;
    logic [OPP_W-1:0]   cur_q, tgt_q, freq_q, volt_q;
    logic [DWELL_W-1:0] dwell_q;
    logic [TEMP_W:0]    temp_ext;
    logic               hot, cool, dwell_ok, go_down, go_up;

    // Classify the sample against the passive level and decide whether to move
    always_comb begin
        temp_ext = {1'b0, temp};
        hot      = temp_ext >= HOT_LVL;
        cool     = (temp_ext + HYST_EXT) < HOT_LVL;
        dwell_ok = dwell_q >= dwell_min;
        go_down  = (state == SEQ_IDLE) && sample_valid && hot  && (cur_q != OPP_LAST) && dwell_ok;
        go_up    = (state == SEQ_IDLE) && sample_valid && cool && (cur_q != '0)       && dwell_ok;
    end

    // Sequence state, selections and dwell counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            cur_q   <= '0;
            tgt_q   <= '0;
            freq_q  <= '0;
            volt_q  <= '0;
            dwell_q <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (go_down) begin
                        tgt_q  <= cur_q + 1'b1;
                        freq_q <= cur_q + 1'b1;
                        state  <= SEQ_DN_VOLT;
                    end else if (go_up) begin
                        tgt_q  <= cur_q - 1'b1;
                        volt_q <= cur_q - 1'b1;
                        state  <= SEQ_UP_WAIT;
                    end else if (sample_valid && (dwell_q != '1)) begin
                        dwell_q <= dwell_q + 1'b1;
                    end
                end
                SEQ_DN_VOLT: begin
                    volt_q <= tgt_q;
                    state  <= SEQ_DN_WAIT;
                end
                SEQ_DN_WAIT: begin
                    if (settle_done) begin
                        cur_q   <= tgt_q;
                        dwell_q <= '0;
                        state   <= SEQ_IDLE;
                    end
                end
                default: begin
                    if (settle_done) begin
                        freq_q  <= tgt_q;
                        cur_q   <= tgt_q;
                        dwell_q <= '0;
                        state   <= SEQ_IDLE;
                    end
                end
            endcase
        end
    end

    assign opp_idx  = cur_q;
    assign freq_sel = freq_q;
    assign volt_sel = volt_q;

endmodule

// File: rtl/tg_skip_ctrl.sv
// Cycle-skip controller.
// Keeps a skip level N (0 .. SKIP_DEN-1) that moves one step per sample around the
// junction limit, and gates off the first N cycles of every SKIP_DEN-cycle window.
// Assumes: SKIP_DEN is a power of two, at least 2.
module tg_skip_ctrl #(
    parameter int TEMP_W   = 8,
    parameter int SKIP_DEN = 8,
    parameter int HYST     = 3,
    localparam int PH_W    = $clog2(SKIP_DEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0] tj_limit,
    input  logic              gate_all,
    output logic [PH_W-1:0]   skip_lvl,
    output logic              clk_en
);
    localparam logic [PH_W-1:0] SKIP_MAX = PH_W'(SKIP_DEN - 1);
    localparam logic [TEMP_W:0] HYST_EXT = (TEMP_W+1)'(HYST);

    logic [PH_W-1:0] lvl_q, phase_q;
    logic            above, below;

    // Compare the sample with the junction limit and its hysteresis floor
    always_comb begin
        above = temp >= tj_limit;
        below = ({1'b0, temp} + HYST_EXT) < {1'b0, tj_limit};
    end

    // Move the skip level by one step per sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (sample_valid) begin
            if (above && (lvl_q != SKIP_MAX)) begin
                lvl_q <= lvl_q + 1'b1;
            end else if (below && (lvl_q != '0)) begin
                lvl_q <= lvl_q - 1'b1;
            end
        end
    end

    // Free-running position inside the skip window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= (phase_q == SKIP_MAX) ? '0 : phase_q + 1'b1;
        end
    end

    assign skip_lvl = lvl_q;
    assign clk_en   = !gate_all && (phase_q >= lvl_q);

endmodule

// File: rtl/tg_trip.sv
// Hard-trip latch.
// Sets on a sample at or above the critical level taken while skipping is
// already active. Only reset clears it.
// Assumes: skip_active reflects the skip level held before the current sample.
module tg_trip #(
    parameter int TEMP_W = 8,
    parameter int CRIT   = 110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [TEMP_W-1:0] temp,
    input  logic              skip_active,
    output logic              trip
);
    localparam logic [TEMP_W:0] CRIT_EXT = (TEMP_W+1)'(CRIT);

    // Sticky latch of the critical condition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip <= 1'b0;
        end else if (sample_valid && skip_active && ({1'b0, temp} >= CRIT_EXT)) begin
            trip <= 1'b1;
        end
    end

endmodule

// File: rtl/thermal_governor.sv
// Thermal governor top.
// Joins the operating-point sequencer, the cycle-skip controller and the trip latch,
// and reports which escalation tier is active.
// Assumes: temp_in is sampled only while sample_valid is high; tj_limit and
// dwell_min are quasi-static.
module thermal_governor #(
    parameter int TEMP_W       = 8,
    parameter int NUM_OPP      = 4,
    parameter int DWELL_W      = 8,
    parameter int SKIP_DEN     = 8,
    parameter int PASSIVE_TRIP = 80,
    parameter int HYST_DEG     = 3,
    parameter int CRIT_TEMP    = 110,
    localparam int OPP_W       = $clog2(NUM_OPP),
    localparam int PH_W        = $clog2(SKIP_DEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_valid,
    input  logic [TEMP_W-1:0]  temp_in,
    input  logic [TEMP_W-1:0]  tj_limit,
    input  logic [DWELL_W-1:0] dwell_min,
    input  logic               settle_done,
    output logic [OPP_W-1:0]   opp_idx,
    output logic [OPP_W-1:0]   freq_sel,
    output logic [OPP_W-1:0]   volt_sel,
    output logic [PH_W-1:0]    skip_level,
    output logic               clk_en,
    output logic               reset_req,
    output logic [1:0]         tier
);
    import thermal_pkg::*;

    tier_e tier_d;

    tg_opp_seq #(
        .TEMP_W (TEMP_W),
        .NUM_OPP(NUM_OPP),
        .DWELL_W(DWELL_W),
        .PASSIVE(PASSIVE_TRIP),
        .HYST   (HYST_DEG)
    ) u_opp (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_valid(sample_valid),
        .temp        (temp_in),
        .dwell_min   (dwell_min),
        .settle_done (settle_done),
        .opp_idx     (opp_idx),
        .freq_sel    (freq_sel),
        .volt_sel    (volt_sel)
    );

    tg_skip_ctrl #(
        .TEMP_W  (TEMP_W),
        .SKIP_DEN(SKIP_DEN),
        .HYST    (HYST_DEG)
    ) u_skip (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_valid(sample_valid),
        .temp        (temp_in),
        .tj_limit    (tj_limit),
        .gate_all    (reset_req),
        .skip_lvl    (skip_level),
        .clk_en      (clk_en)
    );

    tg_trip #(
        .TEMP_W(TEMP_W),
        .CRIT  (CRIT_TEMP)
    ) u_trip (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_valid(sample_valid),
        .temp        (temp_in),
        .skip_active (skip_level != '0),
        .trip        (reset_req)
    );

    // Report the most severe tier in force
    always_comb begin
        if (reset_req)                              tier_d = TIER_TRIP;
        else if (skip_level != '0)                  tier_d = TIER_SKIP;
        else if ((freq_sel != '0) || (volt_sel != '0)) tier_d = TIER_PASSIVE;
        else                                        tier_d = TIER_NONE;
    end

    assign tier = tier_d;

endmodule

// File: rtl/thermal_governor_chk.sv
// Property checker for the thermal governor, attached by bind. Observes ports only.
module thermal_governor_chk #(
    parameter int OPP_W = 2,
    parameter int PH_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_valid,
    input logic             settle_done,
    input logic [OPP_W-1:0] opp_idx,
    input logic [OPP_W-1:0] freq_sel,
    input logic [OPP_W-1:0] volt_sel,
    input logic [PH_W-1:0]  skip_level,
    input logic             clk_en,
    input logic             reset_req
);
    assert_trip_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> reset_req);

    assert_trip_gates_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> !clk_en);

    assert_trip_needs_skip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_req) |-> ($past(sample_valid) && ($past(skip_level) != '0)));

    assert_opp_after_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(opp_idx) |-> $past(settle_done));

    assert_volt_covers_freq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        freq_sel >= volt_sel);

    assert_skip_on_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(skip_level) |-> $past(sample_valid));

    assert_no_skip_full_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((skip_level == '0) && !reset_req) |-> clk_en);

endmodule

bind thermal_governor thermal_governor_chk #(
    .OPP_W(OPP_W),
    .PH_W (PH_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_valid(sample_valid),
    .settle_done (settle_done),
    .opp_idx     (opp_idx),
    .freq_sel    (freq_sel),
    .volt_sel    (volt_sel),
    .skip_level  (skip_level),
    .clk_en      (clk_en),
    .reset_req   (reset_req)
);

// File: tb/test_thermal_governor.sv
module test_thermal_governor;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sample_valid;
    logic [7:0] temp_in;
    logic [7:0] tj_limit;
    logic [7:0] dwell_min;
    logic       settle_done;
    logic [1:0] opp_idx, freq_sel, volt_sel;
    logic [2:0] skip_level;
    logic       clk_en, reset_req;
    logic [1:0] tier;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    thermal_governor i_thermal_governor (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .temp_in(temp_in),
        .tj_limit(tj_limit), .dwell_min(dwell_min), .settle_done(settle_done),
        .opp_idx(opp_idx), .freq_sel(freq_sel), .volt_sel(volt_sel),
        .skip_level(skip_level), .clk_en(clk_en), .reset_req(reset_req), .tier(tier)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic sample(input int t);
        temp_in      = 8'(t);
        sample_valid = 1'b1;
        tick();
        sample_valid = 1'b0;
    endtask

    task automatic settle();
        settle_done = 1'b1;
        tick();
        settle_done = 1'b0;
    endtask

    task automatic count_en(output int n);
        n = 0;
        for (int i = 0; i < 16; i++) begin
            tick();
            n += int'(clk_en);
        end
    endtask

    // Step from cur to cur+1 with dwell d counted since the last completion
    task automatic step_down(input int cur, input int d);
        dwell_min = 8'(d);
        for (int j = 0; j < d; j++) begin
            sample(85);
            chk("R4 dwell blocks step down", freq_sel, cur);
        end
        sample(85);
        chk("R5 freq first on step down", freq_sel, cur + 1);
        chk("R5 volt held on step down",  volt_sel, cur);
        chk("R5 opp held on step down",   opp_idx,  cur);
        tick();
        chk("R5 volt follows next cycle", volt_sel, cur + 1);
        tick(); tick();
        chk("R5 opp waits for settle", opp_idx, cur);
        settle();
        chk("R2 opp stepped down", opp_idx, cur + 1);
        chk("R12 passive tier", tier, 1);
    endtask

    // Step from cur to cur-1 with dwell d
    task automatic step_up(input int cur, input int d);
        dwell_min = 8'(d);
        for (int j = 0; j < d; j++) begin
            sample(76);
            chk("R4 dwell blocks step up", volt_sel, cur);
        end
        sample(76);
        chk("R6 volt first on step up", volt_sel, cur - 1);
        chk("R6 freq held on step up",  freq_sel, cur);
        tick(); tick();
        chk("R6 opp waits for settle", opp_idx, cur);
        chk("R6 freq waits for settle", freq_sel, cur);
        settle();
        chk("R3 opp stepped up", opp_idx, cur - 1);
        chk("R6 freq after settle", freq_sel, cur - 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n, lvl;
        sample_valid = 1'b0; temp_in = 8'd25; tj_limit = 8'd100;
        dwell_min = 8'd255; settle_done = 1'b0; rst_n = 1'b0;
        do_reset();

        // R1 reset state
        chk("R1 opp_idx", opp_idx, 0);
        chk("R1 freq_sel", freq_sel, 0);
        chk("R1 volt_sel", volt_sel, 0);
        chk("R1 skip_level", skip_level, 0);
        chk("R1 clk_en", clk_en, 1);
        chk("R1 reset_req", reset_req, 0);
        chk("R1 R12 tier", tier, 0);

        // R7/R8 sweep of skip level up and back down
        lvl = 0;
        for (int k = 1; k <= 9; k++) begin
            sample(101);
            lvl = (lvl < 7) ? lvl + 1 : 7;
            chk("R7 skip rises", skip_level, lvl);
            chk("R12 skip tier", tier, 2);
            count_en(n);
            chk("R8 enable count", n, 2 * (8 - lvl));
        end
        sample(98); chk("R7 hold in band", skip_level, 7);
        sample(97); chk("R7 hold at floor", skip_level, 7);
        chk("R2 dwell kept opp", opp_idx, 0);
        for (int k = 0; k < 8; k++) begin
            sample(96);
            lvl = (lvl > 0) ? lvl - 1 : 0;
            chk("R7 skip falls", skip_level, lvl);
            count_en(n);
            chk("R8 enable count falling", n, 2 * (8 - lvl));
        end
        chk("R12 tier back to none", tier, 0);

        // R9 alternate junction limit
        tj_limit = 8'd105;
        sample(104); chk("R9 below 105 no skip", skip_level, 0);
        sample(105); chk("R9 at 105 skips", skip_level, 1);
        sample(101); chk("R9 R7 below 102 falls", skip_level, 0);
        tj_limit = 8'd100;

        // Operating-point walk down and up
        do_reset();
        step_down(0, 2);
        step_down(1, 0);
        step_down(2, 3);
        dwell_min = 8'd0;
        for (int k = 0; k < 3; k++) begin
            sample(85);
            chk("R2 slowest entry holds", freq_sel, 3);
            chk("R2 slowest opp holds", opp_idx, 3);
        end
        step_up(3, 0);
        step_up(2, 2);
        dwell_min = 8'd0;
        sample(78); chk("R3 band holds 78", volt_sel, 1);
        sample(77); chk("R3 band holds 77", volt_sel, 1);
        chk("R3 opp held in band", opp_idx, 1);
        step_up(1, 0);
        chk("R12 tier none after recovery", tier, 0);

        // Trip escalation
        do_reset();
        dwell_min = 8'd255;
        sample(112);
        chk("R10 no trip with skip idle", reset_req, 0);
        chk("R10 first hot sample skips", skip_level, 1);
        sample(109);
        chk("R10 109 does not trip", reset_req, 0);
        sample(110);
        chk("R10 trip at 110 while skipping", reset_req, 1);
        chk("R12 trip tier", tier, 3);
        count_en(n);
        chk("R11 clocks gated when tripped", n, 0);
        for (int k = 0; k < 3; k++) begin
            sample(50);
            chk("R11 trip sticky", reset_req, 1);
        end
        do_reset();
        chk("R11 reset clears trip", reset_req, 0);
        count_en(n);
        chk("R11 R8 clocks restored", n, 16);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule